// File: doc/BRIEF.md
# Fill-Level Triggered Burst DMA Master

This block is a bus master that moves words between a local ring buffer and an external memory without per-transfer help from a processor. It sits between local producer or consumer logic and a system bus. Each transfer has two parts. First comes a command phase: the block raises a read or write request with an address, byte enables, a transfer type, a beat count, a lock flag and a reset flag. Then comes a data phase. Writes go out on a framed, active-low data stream, and read data comes back on an active-low handshaked input.

The direction is picked by a static configuration bit. When draining, local logic pushes words into the ring buffer, and the block starts a write burst each time a whole burst is waiting. When filling, the block starts a read burst each time the buffer has room for a whole burst. The returning words pass through a 128-entry staging FIFO before they reach the ring buffer, where local logic pops them. A small register port lets a processor read both ring pointers, the fill level and a sticky error flag.

Top module: `fifo_burst_dma`

## Requirements
- R1: In drain mode (`cfg_dir`=0) with `cfg_en`=1 and no error, a write command is raised only once the ring buffer holds at least BURST words (default 16). The request appears one cycle after the level reaches BURST.
- R2: A raised request stays high until `cmd_ack`, with a stable address. The command shows `cmd_be` all ones, `cmd_burst`=1, `cmd_len`=BURST, `cmd_lock`=0 and `cmd_rst`=0.
- R3: During the write data phase `wr_src_rdy_n` is 0. `wr_sof_n` is 0 only on the first beat and `wr_eof_n` is 0 only on the last beat. `wr_src_dsc_n` is always 1 and `wr_rem` is always 0.
- R4: A beat is taken only in a cycle where `wr_src_rdy_n` and `wr_dst_rdy_n` are both 0. Each taken beat moves the read pointer up by one. While stalled, `wr_d` holds its value.
- R5: Each direction keeps its own byte offset from its base, and the offset grows by DW/8 for every beat. The next write command therefore starts at `cfg_wr_base` + 4·BURST.
- R6: After the last beat the block waits for `cmd_done` and starts no new command before it, even when a full burst is waiting.
- R7: In fill mode (`cfg_dir`=1) a read command at `cfg_rd_base` plus the read offset is raised once free ring space, less the words held in staging, is at least BURST.
- R8: During the read data phase `rd_dst_rdy_n` is 0 while staging has room. Words taken with `rd_src_rdy_n`=0 are moved on into the ring buffer and come out of `lcl_rdata`/`lcl_pop` in arrival order.
- R9: The register port returns the following values by `reg_addr`: 0 gives the ring write pointer, 1 gives the ring read pointer, 2 gives the error flag in bit 0, and 3 gives the ring fill level.
- R10: When `cmd_err` is seen during a transfer, the error flag is set and stays set, and no command is raised again until reset.
- R11: After reset both pointers and the level are 0, the error flag is 0, no request is raised, `wr_src_rdy_n` is 1 and `lcl_empty` is 1.
- R12: A push into a full ring buffer (64 words by default) is ignored. The level stays at 64 and `lcl_full` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Allows new transfers to start |
| cfg_dir | input | 1 | 0 drain buffer to memory, 1 fill buffer from memory |
| cfg_wr_base | input | AW | Base byte address for write bursts |
| cfg_rd_base | input | AW | Base byte address for read bursts |
| lcl_push | input | 1 | Local push into the ring buffer (drain mode) |
| lcl_wdata | input | DW | Word to push |
| lcl_full | output | 1 | Ring buffer full |
| lcl_pop | input | 1 | Local pop from the ring buffer (fill mode) |
| lcl_rdata | output | DW | Word at the ring head |
| lcl_empty | output | 1 | Ring buffer empty |
| cmd_wr_req | output | 1 | Write command request |
| cmd_rd_req | output | 1 | Read command request |
| cmd_addr | output | AW | Command byte address |
| cmd_be | output | DW/8 | Byte enables |
| cmd_burst | output | 1 | Transfer type, 1 = burst |
| cmd_len | output | LW | Beats in the transfer |
| cmd_lock | output | 1 | Bus lock, held 0 |
| cmd_rst | output | 1 | Master reset to bus, held 0 |
| cmd_ack | input | 1 | Command accepted |
| cmd_done | input | 1 | Transfer complete |
| cmd_err | input | 1 | Transfer error |
| wr_d | output | DW | Write stream data |
| wr_src_rdy_n | output | 1 | Write stream source ready, active low |
| wr_sof_n | output | 1 | First beat marker, active low |
| wr_eof_n | output | 1 | Last beat marker, active low |
| wr_src_dsc_n | output | 1 | Source discontinue, held inactive |
| wr_rem | output | DW/8 | Remainder field, held 0 |
| wr_dst_rdy_n | input | 1 | Write stream destination ready, active low |
| rd_d | input | DW | Read data from memory |
| rd_src_rdy_n | input | 1 | Read data valid, active low |
| rd_dst_rdy_n | output | 1 | Read data accepted, active low |
| reg_addr | input | 2 | Register select |
| reg_rdata | output | DW | Register read value |

## Verification
The hardest state to reach is a full burst already waiting while the block is still parked after its last beat, because the done indication has not yet come. Only that state shows that the block waits for completion rather than reacting to the fill level. The bench streams one burst, holds back `cmd_done`, and pushes sixteen more words during the wait. It then checks that no request appears until done is pulsed, and that the next command lands one burst further on. The sticky error is reached the same way, by answering that second burst with `cmd_err` and then refilling the buffer.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WCMD,
    S_WDATA,
    S_WWAIT,
    S_RCMD,
    S_RDATA,
    S_RWAIT
  } fbd_state_e;

  localparam logic DIR_TO_MEM   = 1'b0;
  localparam logic DIR_FROM_MEM = 1'b1;
endpackage

// File: rtl/fbd_ring_buf.sv
module fbd_ring_buf #(
  parameter int DW    = 32,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic [PTR_W:0]   wr_ptr,
  output logic [PTR_W:0]   rd_ptr,
  output logic [PTR_W:0]   level,
  output logic             full,
  output logic             empty
);
  localparam int DEPTH = 1 << PTR_W;
  localparam logic [PTR_W:0] DEPTH_L = {1'b1, {PTR_W{1'b0}}};

  logic [DW-1:0]  mem [DEPTH];
  logic [PTR_W:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic           push_ok, pop_ok;

  assign level   = wr_ptr_q - rd_ptr_q;
  assign full    = (level == DEPTH_L);
  assign empty   = (level == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rd_ptr_q[PTR_W-1:0]];
  assign wr_ptr  = wr_ptr_q;
  assign rd_ptr  = rd_ptr_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push_ok) wr_ptr_d = wr_ptr_q + 1'b1;
    if (pop_ok)  rd_ptr_d = rd_ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q[PTR_W-1:0]] <= push_data;
  end

  p_level_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH_L);
  p_rd_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr_q != $past(rd_ptr_q)) |-> (rd_ptr_q == $past(rd_ptr_q) + 1'b1));
endmodule

// File: rtl/fbd_xfer_ctl.sv
module fbd_xfer_ctl
  import fbd_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int PTR_W  = 6,
  parameter int STG_W  = 7,
  parameter int BURST  = 16,
  localparam int LW    = $clog2(BURST + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_en,
  input  logic           cfg_dir,
  input  logic [AW-1:0]  cfg_wr_base,
  input  logic [AW-1:0]  cfg_rd_base,
  input  logic [PTR_W:0] buf_level,
  input  logic [STG_W:0] stg_level,
  input  logic           stg_full,
  input  logic           cmd_ack,
  input  logic           cmd_done,
  input  logic           cmd_err,
  input  logic           wr_dst_rdy_n,
  input  logic           rd_src_rdy_n,
  output logic           cmd_wr_req,
  output logic           cmd_rd_req,
  output logic [AW-1:0]  cmd_addr,
  output logic [LW-1:0]  cmd_len,
  output logic           wr_src_rdy_n,
  output logic           wr_sof_n,
  output logic           wr_eof_n,
  output logic           wr_beat_ok,
  output logic           rd_dst_rdy_n,
  output logic           rd_beat_ok,
  output logic           err_flag
);
  localparam int DEPTH = 1 << PTR_W;
  localparam int BCW   = (BURST > 1) ? $clog2(BURST) : 1;
  localparam logic [BCW-1:0] LAST_BEAT = BCW'(BURST - 1);
  localparam logic [AW-1:0]  STEP      = AW'(DW / 8);

  fbd_state_e     state_q, state_d;
  logic [BCW-1:0] beat_q, beat_d;
  logic [AW-1:0]  wr_off_q, wr_off_d, rd_off_q, rd_off_d;
  logic           err_q, err_d;
  logic           wr_go, rd_go, room_ok, last, busy;

  assign room_ok = (int'(buf_level) + int'(stg_level) + BURST) <= DEPTH;
  assign wr_go   = cfg_en & ~err_q & (cfg_dir == DIR_TO_MEM) & (int'(buf_level) >= BURST);
  assign rd_go   = cfg_en & ~err_q & (cfg_dir == DIR_FROM_MEM) & room_ok;
  assign last    = (beat_q == LAST_BEAT);
  assign busy    = (state_q != S_IDLE);

  assign cmd_wr_req   = (state_q == S_WCMD);
  assign cmd_rd_req   = (state_q == S_RCMD);
  assign cmd_addr     = (state_q == S_RCMD) ? (cfg_rd_base + rd_off_q) : (cfg_wr_base + wr_off_q);
  assign cmd_len      = LW'(BURST);
  assign wr_src_rdy_n = ~(state_q == S_WDATA);
  assign wr_sof_n     = ~((state_q == S_WDATA) && (beat_q == '0));
  assign wr_eof_n     = ~((state_q == S_WDATA) && last);
  assign wr_beat_ok   = (state_q == S_WDATA) & ~wr_dst_rdy_n;
  assign rd_dst_rdy_n = ~((state_q == S_RDATA) & ~stg_full);
  assign rd_beat_ok   = (state_q == S_RDATA) & ~stg_full & ~rd_src_rdy_n;
  assign err_flag     = err_q;

  always_comb begin
    state_d  = state_q;
    beat_d   = beat_q;
    wr_off_d = wr_off_q;
    rd_off_d = rd_off_q;
    err_d    = err_q;
    unique case (state_q)
      S_IDLE: begin
        beat_d = '0;
        if (wr_go)      state_d = S_WCMD;
        else if (rd_go) state_d = S_RCMD;
      end
      S_WCMD:  if (cmd_ack) state_d = S_WDATA;
      S_WDATA: if (wr_beat_ok) begin
        wr_off_d = wr_off_q + STEP;
        beat_d   = last ? '0 : beat_q + 1'b1;
        if (last) state_d = S_WWAIT;
      end
      S_WWAIT: if (cmd_done) state_d = S_IDLE;
      S_RCMD:  if (cmd_ack) state_d = S_RDATA;
      S_RDATA: if (rd_beat_ok) begin
        rd_off_d = rd_off_q + STEP;
        beat_d   = last ? '0 : beat_q + 1'b1;
        if (last) state_d = S_RWAIT;
      end
      S_RWAIT: if (cmd_done) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (busy && cmd_err) begin
      err_d   = 1'b1;
      state_d = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      beat_q   <= '0;
      wr_off_q <= '0;
      rd_off_q <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      beat_q   <= beat_d;
      wr_off_q <= wr_off_d;
      rd_off_q <= rd_off_d;
      err_q    <= err_d;
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_req && !cmd_ack && !cmd_err) |=> (cmd_wr_req && $stable(cmd_addr)));
  p_sof_in_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sof_n |-> !wr_src_rdy_n);
  p_eof_then_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_eof_n && !wr_dst_rdy_n) |=> (wr_src_rdy_n && !cmd_wr_req));
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!cmd_wr_req && !cmd_rd_req));
endmodule

// File: rtl/fifo_burst_dma.sv
module fifo_burst_dma
  import fbd_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int PTR_W  = 6,
  parameter int STG_W  = 7,
  parameter int BURST  = 16,
  localparam int LW    = $clog2(BURST + 1),
  localparam int BEW   = DW / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_dir,
  input  logic [AW-1:0]   cfg_wr_base,
  input  logic [AW-1:0]   cfg_rd_base,
  input  logic            lcl_push,
  input  logic [DW-1:0]   lcl_wdata,
  output logic            lcl_full,
  input  logic            lcl_pop,
  output logic [DW-1:0]   lcl_rdata,
  output logic            lcl_empty,
  output logic            cmd_wr_req,
  output logic            cmd_rd_req,
  output logic [AW-1:0]   cmd_addr,
  output logic [BEW-1:0]  cmd_be,
  output logic            cmd_burst,
  output logic [LW-1:0]   cmd_len,
  output logic            cmd_lock,
  output logic            cmd_rst,
  input  logic            cmd_ack,
  input  logic            cmd_done,
  input  logic            cmd_err,
  output logic [DW-1:0]   wr_d,
  output logic            wr_src_rdy_n,
  output logic            wr_sof_n,
  output logic            wr_eof_n,
  output logic            wr_src_dsc_n,
  output logic [BEW-1:0]  wr_rem,
  input  logic            wr_dst_rdy_n,
  input  logic [DW-1:0]   rd_d,
  input  logic            rd_src_rdy_n,
  output logic            rd_dst_rdy_n,
  input  logic [1:0]      reg_addr,
  output logic [DW-1:0]   reg_rdata
);
  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic           buf_push, buf_pop, buf_full, buf_empty;
  logic [DW-1:0]  buf_wdata, buf_head;
  logic [PTR_W:0] buf_wr_ptr, buf_rd_ptr, buf_level;
  logic           stg_push, stg_pop, stg_full, stg_empty;
  logic [DW-1:0]  stg_head;
  logic [STG_W:0] stg_level, stg_wr_ptr_unused, stg_rd_ptr_unused;
  logic           wr_beat_ok, rd_beat_ok, err_flag;

  // Reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Ring buffer input and output sources follow the direction bit
  assign stg_pop   = (cfg_dir == DIR_FROM_MEM) & ~stg_empty & ~buf_full;
  assign buf_push  = (cfg_dir == DIR_FROM_MEM) ? stg_pop  : lcl_push;
  assign buf_wdata = (cfg_dir == DIR_FROM_MEM) ? stg_head : lcl_wdata;
  assign buf_pop   = (cfg_dir == DIR_FROM_MEM) ? lcl_pop  : wr_beat_ok;
  assign stg_push  = rd_beat_ok;

  fbd_ring_buf #(.DW(DW), .PTR_W(PTR_W)) u_ring (
    .clk(clk), .rst_n(rst_int_n),
    .push(buf_push), .push_data(buf_wdata), .pop(buf_pop),
    .head(buf_head), .wr_ptr(buf_wr_ptr), .rd_ptr(buf_rd_ptr),
    .level(buf_level), .full(buf_full), .empty(buf_empty)
  );

  fbd_ring_buf #(.DW(DW), .PTR_W(STG_W)) u_stage (
    .clk(clk), .rst_n(rst_int_n),
    .push(stg_push), .push_data(rd_d), .pop(stg_pop),
    .head(stg_head), .wr_ptr(stg_wr_ptr_unused), .rd_ptr(stg_rd_ptr_unused),
    .level(stg_level), .full(stg_full), .empty(stg_empty)
  );

  fbd_xfer_ctl #(.AW(AW), .DW(DW), .PTR_W(PTR_W), .STG_W(STG_W), .BURST(BURST)) u_ctl (
    .clk(clk), .rst_n(rst_int_n),
    .cfg_en(cfg_en), .cfg_dir(cfg_dir),
    .cfg_wr_base(cfg_wr_base), .cfg_rd_base(cfg_rd_base),
    .buf_level(buf_level), .stg_level(stg_level), .stg_full(stg_full),
    .cmd_ack(cmd_ack), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .wr_dst_rdy_n(wr_dst_rdy_n), .rd_src_rdy_n(rd_src_rdy_n),
    .cmd_wr_req(cmd_wr_req), .cmd_rd_req(cmd_rd_req),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_src_rdy_n(wr_src_rdy_n), .wr_sof_n(wr_sof_n), .wr_eof_n(wr_eof_n),
    .wr_beat_ok(wr_beat_ok), .rd_dst_rdy_n(rd_dst_rdy_n),
    .rd_beat_ok(rd_beat_ok), .err_flag(err_flag)
  );

  assign cmd_be       = '1;
  assign cmd_burst    = (BURST > 1);
  assign cmd_lock     = 1'b0;
  assign cmd_rst      = 1'b0;
  assign wr_src_dsc_n = 1'b1;
  assign wr_rem       = '0;
  assign wr_d         = buf_head;
  assign lcl_rdata    = buf_head;
  assign lcl_full     = buf_full;
  assign lcl_empty    = buf_empty;

  always_comb begin
    unique case (reg_addr)
      2'd0:    reg_rdata = DW'(buf_wr_ptr);
      2'd1:    reg_rdata = DW'(buf_rd_ptr);
      2'd2:    reg_rdata = DW'(err_flag);
      default: reg_rdata = DW'(buf_level);
    endcase
  end

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!wr_src_rdy_n && wr_dst_rdy_n && !cmd_err) |=> (!wr_src_rdy_n && $stable(wr_d)));
  p_stage_room_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_dst_rdy_n |-> !stg_full);
endmodule

// File: tb/test_fifo_burst_dma.sv
module test_fifo_burst_dma;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [31:0] WR_BASE = 32'h1000_0000;
  localparam logic [31:0] RD_BASE = 32'h2000_0400;

  typedef struct packed {
    logic [31:0] add;
    logic [31:0] lvl;
    logic [31:0] req;
  } vec_t;
  localparam vec_t VEC [4] = '{
    '{32'd5, 32'd5,  32'd0},
    '{32'd9, 32'd14, 32'd0},
    '{32'd1, 32'd15, 32'd0},
    '{32'd1, 32'd16, 32'd1}
  };

  logic clk, rst_n, cfg_en, cfg_dir;
  logic lcl_push, lcl_pop, lcl_full, lcl_empty;
  logic [DW-1:0] lcl_wdata, lcl_rdata, wr_d, rd_d, reg_rdata;
  logic cmd_wr_req, cmd_rd_req, cmd_burst, cmd_lock, cmd_rst;
  logic cmd_ack, cmd_done, cmd_err;
  logic [AW-1:0] cmd_addr;
  logic [3:0] cmd_be, wr_rem;
  logic [4:0] cmd_len;
  logic wr_src_rdy_n, wr_sof_n, wr_eof_n, wr_src_dsc_n, wr_dst_rdy_n;
  logic rd_src_rdy_n, rd_dst_rdy_n;
  logic [1:0] reg_addr;

  int checks = 0;
  int errors = 0;
  int push_n = 0;

  fifo_burst_dma i_fifo_burst_dma (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dir(cfg_dir),
    .cfg_wr_base(WR_BASE), .cfg_rd_base(RD_BASE),
    .lcl_push(lcl_push), .lcl_wdata(lcl_wdata), .lcl_full(lcl_full),
    .lcl_pop(lcl_pop), .lcl_rdata(lcl_rdata), .lcl_empty(lcl_empty),
    .cmd_wr_req(cmd_wr_req), .cmd_rd_req(cmd_rd_req), .cmd_addr(cmd_addr),
    .cmd_be(cmd_be), .cmd_burst(cmd_burst), .cmd_len(cmd_len),
    .cmd_lock(cmd_lock), .cmd_rst(cmd_rst),
    .cmd_ack(cmd_ack), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .wr_d(wr_d), .wr_src_rdy_n(wr_src_rdy_n), .wr_sof_n(wr_sof_n),
    .wr_eof_n(wr_eof_n), .wr_src_dsc_n(wr_src_dsc_n), .wr_rem(wr_rem),
    .wr_dst_rdy_n(wr_dst_rdy_n),
    .rd_d(rd_d), .rd_src_rdy_n(rd_src_rdy_n), .rd_dst_rdy_n(rd_dst_rdy_n),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic push_word();
    lcl_push  = 1'b1;
    lcl_wdata = 32'hA000_0000 + 32'(push_n);
    push_n++;
    @(negedge clk);
    lcl_push = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; cfg_en = 1'b1; cfg_dir = 1'b0;
    lcl_push = 1'b0; lcl_pop = 1'b0; lcl_wdata = '0;
    cmd_ack = 1'b0; cmd_done = 1'b0; cmd_err = 1'b0;
    wr_dst_rdy_n = 1'b1; rd_d = '0; rd_src_rdy_n = 1'b1; reg_addr = 2'd0;
    @(negedge clk);
    do_reset();

    // R11 reset state
    chk("R11 wr_req", 32'(cmd_wr_req), 0);
    chk("R11 rd_req", 32'(cmd_rd_req), 0);
    chk("R11 src_rdy_n", 32'(wr_src_rdy_n), 1);
    chk("R11 lcl_empty", 32'(lcl_empty), 1);
    chk("R3 dsc_n idle", 32'(wr_src_dsc_n), 1);
    chk("R3 rem idle", 32'(wr_rem), 0);
    rd_reg(2'd0, v); chk("R11 wr_ptr", v, 0);
    rd_reg(2'd2, v); chk("R11 err", v, 0);

    // R1 / R9 fill-level table
    foreach (VEC[i]) begin
      for (int n = 0; n < int'(VEC[i].add); n++) push_word();
      @(negedge clk);
      rd_reg(2'd3, v); chk("R9 level", v, VEC[i].lvl);
      chk("R1 wr_req vs level", 32'(cmd_wr_req), VEC[i].req);
    end

    // R2 command fields and hold without ack
    chk("R2 addr", cmd_addr, WR_BASE);
    chk("R2 be", 32'(cmd_be), 32'hF);
    chk("R2 burst", 32'(cmd_burst), 1);
    chk("R2 len", 32'(cmd_len), 16);
    chk("R2 lock", 32'(cmd_lock), 0);
    chk("R2 rst", 32'(cmd_rst), 0);
    repeat (3) @(negedge clk);
    chk("R2 held no ack", 32'(cmd_wr_req), 1);
    chk("R2 addr stable", cmd_addr, WR_BASE);
    pulse(cmd_ack);
    chk("R2 req drop after ack", 32'(cmd_wr_req), 0);

    // R3 / R4 framed stream with a stall
    for (int k = 0; k < 16; k++) begin
      chk("R3 src_rdy_n", 32'(wr_src_rdy_n), 0);
      chk("R3 sof_n", 32'(wr_sof_n), 32'(k != 0));
      chk("R3 eof_n", 32'(wr_eof_n), 32'(k != 15));
      chk("R3 dsc_n", 32'(wr_src_dsc_n), 1);
      chk("R4 data", wr_d, 32'hA000_0000 + 32'(k));
      if (k == 3) begin
        wr_dst_rdy_n = 1'b1;
        @(negedge clk);
        chk("R4 stall data held", wr_d, 32'hA000_0003);
        rd_reg(2'd1, v); chk("R4 no advance on stall", v, 3);
      end
      wr_dst_rdy_n = 1'b0;
      @(negedge clk);
    end
    wr_dst_rdy_n = 1'b1;
    chk("R6 src idle after last", 32'(wr_src_rdy_n), 1);
    rd_reg(2'd1, v); chk("R9 rd_ptr", v, 16);
    rd_reg(2'd0, v); chk("R9 wr_ptr", v, 16);
    chk("R5 offset after burst", cmd_addr, WR_BASE + 32'd64);

    // R6 full burst waiting, no done yet
    for (int n = 0; n < 16; n++) push_word();
    repeat (3) @(negedge clk);
    chk("R6 no req before done", 32'(cmd_wr_req), 0);
    pulse(cmd_done);
    @(negedge clk);
    chk("R6 req after done", 32'(cmd_wr_req), 1);
    chk("R5 second burst addr", cmd_addr, WR_BASE + 32'd64);
    pulse(cmd_ack);
    wr_dst_rdy_n = 1'b0;
    chk("R4 second burst head", wr_d, 32'hA000_0010);
    repeat (16) @(negedge clk);
    wr_dst_rdy_n = 1'b1;

    // R10 error sticky
    pulse(cmd_err);
    rd_reg(2'd2, v); chk("R10 err flag", v, 1);
    for (int n = 0; n < 16; n++) push_word();
    repeat (4) @(negedge clk);
    chk("R10 no req after err", 32'(cmd_wr_req), 0);
    rd_reg(2'd3, v); chk("R10 level waiting", v, 16);
    rd_reg(2'd2, v); chk("R10 err still set", v, 1);

    // R11 reset clears
    do_reset();
    rd_reg(2'd2, v); chk("R11 err cleared", v, 0);
    rd_reg(2'd3, v); chk("R11 level cleared", v, 0);
    chk("R11 no req", 32'(cmd_wr_req), 0);

    // R7 / R8 fill direction
    cfg_dir = 1'b1;
    @(negedge clk);
    chk("R7 rd_req", 32'(cmd_rd_req), 1);
    chk("R7 rd addr", cmd_addr, RD_BASE);
    chk("R7 no wr_req", 32'(cmd_wr_req), 0);
    pulse(cmd_ack);
    cfg_en = 1'b0;
    chk("R8 dst_rdy_n", 32'(rd_dst_rdy_n), 0);
    for (int k = 0; k < 16; k++) begin
      rd_src_rdy_n = 1'b0;
      rd_d = 32'hB000_0000 + 32'(k);
      @(negedge clk);
    end
    rd_src_rdy_n = 1'b1;
    chk("R8 dst idle after burst", 32'(rd_dst_rdy_n), 1);
    pulse(cmd_done);
    repeat (3) @(negedge clk);
    rd_reg(2'd3, v); chk("R8 level filled", v, 16);
    for (int k = 0; k < 16; k++) begin
      chk("R8 pop order", lcl_rdata, 32'hB000_0000 + 32'(k));
      lcl_pop = 1'b1;
      @(negedge clk);
    end
    lcl_pop = 1'b0;
    chk("R8 empty after pops", 32'(lcl_empty), 1);

    // R12 push into full buffer
    cfg_dir = 1'b0;
    for (int n = 0; n < 65; n++) push_word();
    rd_reg(2'd3, v); chk("R12 level capped", v, 64);
    chk("R12 full", 32'(lcl_full), 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule